// File: doc/BRIEF.md
# Vertical Sync Windowing and Flywheel

This block turns raw vertical-sync detections from a sync separator into a clean field-start pulse. All timing is kept in half-line units. A strobe arrives once per half line, so a 625-line field is 625 half-lines, and 312.5 lines is an exact count. Every half line a position counter advances. A field starts in one of four ways: a raw pulse is accepted, the flywheel fills in a missing pulse at the nominal field length, a fallback timeout expires, or the free-running generator fires. Each start restarts the counter and launches a VS pulse three lines long.

A noise gate can be switched on. Raw pulses then count only when they fall inside a narrow or a wide window around the expected field length. The gate and the flywheel are enabled independently. A free-run mode ignores the input and makes fields of 312.5 or 262.5 lines. Terminal mode shortens free-run fields to 312 or 262 lines. The block also keeps a field-identity bit, and it classifies each measured field length into a two-bit range code with hysteresis.

Top module: `vsp_vertical_proc`

## Requirements
- R1: While reset is asserted, `vs_out` is 0, `field_bit` is 0 and `range_code` is 2'b10.
- R2: With free-run off and the noise gate off, a raw pulse (`vp_raw` high on a `half_tick` cycle) starts a field on that half line, whatever the position.
- R3: With the noise gate on, a raw pulse is ignored unless the position (half-lines since the last field start, first half line = 1) lies in [N-W, N+W]. N is 625 with `std_625`=1 and 525 with `std_625`=0.
- R4: With free-run off and no accepted pulse, a field starts at position 680 (625 standard) or 576 (525 standard), even when the flywheel is off.
- R5: With the flywheel on and free-run off, a field starts at position N if no pulse was accepted earlier.
- R6: In free-run mode, `vp_raw` has no effect and fields start every N half-lines. With `term_mode` also set, they start every N-1 half-lines (624 or 524).
- R7: `vs_out` goes high on the clock after the half line that starts a field, and stays high for 6 half-line strobes.
- R8: `field_bit` inverts at every field start. It is instead cleared when the start comes from a pulse accepted with the gate on, inside the window, while `first_half` is high.
- R9: Each field's length L gives a candidate code: bit 1 is set when L > 574, and bit 0 is set when |L - N'| > W, where N' is 625 if bit 1 is set and 525 otherwise. `range_code` takes on a candidate only after four consecutive fields give that candidate.
- R10: The window half-width W is 8 half-lines with `win_wide`=0 and 32 with `win_wide`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | One-cycle strobe per half line |
| vp_raw | input | 1 | Raw vertical pulse, sampled on `half_tick` |
| first_half | input | 1 | Raw pulse lies in the first half of a line |
| std_625 | input | 1 | 1: 625-line standard, 0: 525-line standard |
| win_wide | input | 1 | 1: wide window, 0: narrow window |
| gate_en | input | 1 | Noise gate enable |
| fly_en | input | 1 | Flywheel enable |
| free_run | input | 1 | Free-running field generation |
| term_mode | input | 1 | Integer-line field length in free run |
| vs_out | output | 1 | Vertical sync output pulse |
| field_bit | output | 1 | Field identity bit |
| range_code | output | 2 | Filtered field-length class |

## Verification
A corrupted position counter moves the next VS rise. The bench measures the spacing between VS rises in half lines, so this error appears within one field. A wrong pulse-stretch count changes the width of `vs_out`, and a wrong field-bit update changes `field_bit`; both appear within a few cycles of the start. The reference model is compared on every clock, so either error is caught on the first cycle where it differs. A hysteresis error shows up only after four fields, when `range_code` switches early, switches late, or does not switch.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  typedef logic [1:0] range_t;
  localparam range_t RANGE_AT_RESET = 2'b10;
endpackage

// File: rtl/vsp_field_timer.sv
module vsp_field_timer #(
  parameter int CW     = 10,
  parameter int N625   = 625,
  parameter int N525   = 525,
  parameter int TO625  = 680,
  parameter int TO525  = 576,
  parameter int NARROW = 8,
  parameter int WIDE   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          vp,
  input  logic          std_625,
  input  logic          win_wide,
  input  logic          gate_en,
  input  logic          fly_en,
  input  logic          free_run,
  input  logic          term_mode,
  output logic          field_start,
  output logic          accepted,
  output logic          in_win,
  output logic [CW-1:0] pos
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] nominal, period, limit, half_w;

  always_comb begin
    nominal  = std_625 ? CW'(N625) : CW'(N525);
    half_w   = win_wide ? CW'(WIDE) : CW'(NARROW);
    period   = (free_run && term_mode) ? nominal - 1'b1 : nominal;
    limit    = std_625 ? CW'(TO625) : CW'(TO525);
    pos      = cnt_q + 1'b1;
    in_win   = (pos >= nominal - half_w) && (pos <= nominal + half_w);
    accepted = tick && !free_run && vp && (!gate_en || in_win);
    if (!tick)
      field_start = 1'b0;
    else if (free_run)
      field_start = (pos >= period);
    else
      field_start = accepted || (fly_en && pos >= period) || (pos >= limit);
    cnt_d = cnt_q;
    if (tick)
      cnt_d = field_start ? '0 : pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vsp_vs_stretch.sv
module vsp_vs_stretch #(
  parameter int VS_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic vs
);
  localparam int VW = $clog2(VS_LEN + 1);
  logic [VW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (start)
      left_d = VW'(VS_LEN);
    else if (tick && left_q != '0)
      left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign vs = (left_q != '0);
endmodule

// File: rtl/vsp_range_filter.sv
module vsp_range_filter
  import vsp_pkg::*;
#(
  parameter int CW     = 10,
  parameter int N625   = 625,
  parameter int N525   = 525,
  parameter int SPLIT  = 574,
  parameter int NARROW = 8,
  parameter int WIDE   = 32,
  parameter int HYST   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] pos,
  input  logic          win_wide,
  output range_t        range_code
);
  localparam int AW = (HYST > 1) ? $clog2(HYST) : 1;
  range_t        range_q, range_d, cand_q, cand_d, cand;
  logic [AW-1:0] agree_q, agree_d;
  logic [CW-1:0] ref_len, dev, half_w;
  logic          long_f;

  always_comb begin
    half_w  = win_wide ? CW'(WIDE) : CW'(NARROW);
    long_f  = pos > CW'(SPLIT);
    ref_len = long_f ? CW'(N625) : CW'(N525);
    dev     = (pos >= ref_len) ? pos - ref_len : ref_len - pos;
    cand    = {long_f, dev > half_w};
    range_d = range_q;
    cand_d  = cand_q;
    agree_d = agree_q;
    if (start) begin
      if (cand == range_q) begin
        agree_d = '0;
      end else if (cand == cand_q) begin
        if (agree_q == AW'(HYST - 1)) begin
          range_d = cand;
          agree_d = '0;
        end else begin
          agree_d = agree_q + 1'b1;
        end
      end else begin
        cand_d  = cand;
        agree_d = AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_q <= RANGE_AT_RESET;
      cand_q  <= RANGE_AT_RESET;
      agree_q <= '0;
    end else begin
      range_q <= range_d;
      cand_q  <= cand_d;
      agree_q <= agree_d;
    end
  end

  assign range_code = range_q;
endmodule

// File: rtl/vsp_vertical_proc.sv
module vsp_vertical_proc
  import vsp_pkg::*;
#(
  parameter int CW     = 10,
  parameter int N625   = 625,
  parameter int N525   = 525,
  parameter int TO625  = 680,
  parameter int TO525  = 576,
  parameter int SPLIT  = 574,
  parameter int NARROW = 8,
  parameter int WIDE   = 32,
  parameter int HYST   = 4,
  parameter int VS_LEN = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick,
  input  logic       vp_raw,
  input  logic       first_half,
  input  logic       std_625,
  input  logic       win_wide,
  input  logic       gate_en,
  input  logic       fly_en,
  input  logic       free_run,
  input  logic       term_mode,
  output logic       vs_out,
  output logic       field_bit,
  output logic [1:0] range_code
);
  logic          field_start, accepted, in_win;
  logic [CW-1:0] pos;
  logic          fb_q, fb_d;
  range_t        rc;

  vsp_field_timer #(
    .CW(CW), .N625(N625), .N525(N525), .TO625(TO625), .TO525(TO525),
    .NARROW(NARROW), .WIDE(WIDE)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(half_tick), .vp(vp_raw),
    .std_625(std_625), .win_wide(win_wide), .gate_en(gate_en),
    .fly_en(fly_en), .free_run(free_run), .term_mode(term_mode),
    .field_start(field_start), .accepted(accepted), .in_win(in_win),
    .pos(pos)
  );

  vsp_vs_stretch #(.VS_LEN(VS_LEN)) u_vs (
    .clk(clk), .rst_n(rst_n), .tick(half_tick), .start(field_start),
    .vs(vs_out)
  );

  vsp_range_filter #(
    .CW(CW), .N625(N625), .N525(N525), .SPLIT(SPLIT),
    .NARROW(NARROW), .WIDE(WIDE), .HYST(HYST)
  ) u_range (
    .clk(clk), .rst_n(rst_n), .start(field_start), .pos(pos),
    .win_wide(win_wide), .range_code(rc)
  );

  always_comb begin
    fb_d = fb_q;
    if (field_start)
      fb_d = (accepted && gate_en && in_win && first_half) ? 1'b0 : !fb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= 1'b0;
    else        fb_q <= fb_d;
  end

  assign field_bit  = fb_q;
  assign range_code = rc;
endmodule

// File: rtl/vsp_checker.sv
module vsp_checker #(
  parameter int CW     = 10,
  parameter int N625   = 625,
  parameter int N525   = 525,
  parameter int VS_LEN = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          half_tick,
  input logic          vp_raw,
  input logic          std_625,
  input logic          gate_en,
  input logic          fly_en,
  input logic          free_run,
  input logic          vs_out,
  input logic          field_bit,
  input logic [1:0]    range_code,
  input logic          field_start,
  input logic [CW-1:0] pos
);
  logic [7:0]    hi_ticks;
  logic [CW-1:0] nominal;

  assign nominal = std_625 ? CW'(N625) : CW'(N525);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    hi_ticks <= '0;
    else if (field_start || !vs_out) hi_ticks <= '0;
    else if (half_tick)            hi_ticks <= hi_ticks + 1'b1;
  end

  // R7
  vs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_out) |-> $past(half_tick));

  // R7
  vs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ticks <= 8'(VS_LEN));

  // R2
  gate_off_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && vp_raw && !gate_en && !free_run) |-> field_start);

  // R5
  flywheel_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && fly_en && !free_run && pos == nominal) |-> field_start);

  // R6
  free_run_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && free_run && vp_raw && pos < CW'(N525 - 1)) |-> !field_start);

  // R8
  field_bit_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_bit) |-> $past(field_start));

  // R9
  range_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(range_code) |-> $past(field_start));
endmodule

bind vsp_vertical_proc vsp_checker #(
  .CW(CW), .N625(N625), .N525(N525), .VS_LEN(VS_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .vp_raw(vp_raw),
  .std_625(std_625), .gate_en(gate_en), .fly_en(fly_en),
  .free_run(free_run), .vs_out(vs_out), .field_bit(field_bit),
  .range_code(range_code), .field_start(field_start), .pos(pos)
);

// File: tb/test_vsp_vertical_proc.sv
module test_vsp_vertical_proc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic half_tick = 1'b0, vp_raw = 1'b0, first_half = 1'b0;
  logic std_625 = 1'b1, win_wide = 1'b0, gate_en = 1'b0, fly_en = 1'b0;
  logic free_run = 1'b1, term_mode = 1'b0;
  logic vs_out, field_bit;
  logic [1:0] range_code;

  int n_chk = 0, n_fail = 0;
  int since = 0, pulse_at = 0, nrise = 0, last_iv = 0;
  bit tph = 1'b0, vs_prev = 1'b0, last_fb = 1'b0, done = 1'b0;

  // reference model state
  int m_c, m_vs, m_streak;
  bit m_fb;
  int m_range, m_cand;

  vsp_vertical_proc i_vsp_vertical_proc (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .vp_raw(vp_raw),
    .first_half(first_half), .std_625(std_625), .win_wide(win_wide),
    .gate_en(gate_en), .fly_en(fly_en), .free_run(free_run),
    .term_mode(term_mode), .vs_out(vs_out), .field_bit(field_bit),
    .range_code(range_code)
  );

  always #2 clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c = 0; m_vs = 0; m_fb = 1'b0; m_range = 2; m_cand = 2; m_streak = 0;
    end else if (half_tick) begin
      int n, w, p, t, pos, cnd, rf, dv;
      bit inw, acc, st, lng;
      n   = std_625 ? 625 : 525;
      w   = win_wide ? 32 : 8;
      t   = std_625 ? 680 : 576;
      p   = (free_run && term_mode) ? n - 1 : n;
      pos = m_c + 1;
      inw = (pos >= n - w) && (pos <= n + w);
      acc = !free_run && vp_raw && (!gate_en || inw);
      if (free_run) st = pos >= p;
      else          st = acc || (fly_en && pos >= p) || pos >= t;
      if (m_vs > 0) m_vs--;
      if (st) begin
        m_c  = 0;
        m_vs = 6;
        m_fb = (acc && gate_en && inw && first_half) ? 1'b0 : !m_fb;
        lng = pos > 574;
        rf  = lng ? 625 : 525;
        dv  = pos > rf ? pos - rf : rf - pos;
        cnd = (lng ? 2 : 0) + (dv > w ? 1 : 0);
        if (cnd == m_range) m_streak = 0;
        else if (cnd == m_cand && m_streak > 0) m_streak++;
        else begin m_cand = cnd; m_streak = 1; end
        if (m_streak == 4) begin m_range = cnd; m_streak = 0; end
      end else begin
        m_c = pos;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(vs_out == (m_vs != 0), "R7 vs_out", vs_out, m_vs != 0);
      check(field_bit == m_fb, "R8 field_bit", field_bit, m_fb);
      check(range_code == m_range, "R9 range_code", range_code, m_range);
      if (vs_out && !vs_prev) begin
        last_iv = since;
        last_fb = field_bit;
        since   = 0;
        nrise++;
      end
      vs_prev = vs_out;
    end
    tph = !tph;
    half_tick = tph;
    if (tph) since++;
    vp_raw = tph && (pulse_at != 0) && (since == pulse_at);
  end

  task automatic next_rise();
    int n0 = nrise;
    wait (nrise != n0);
  endtask

  task automatic expect_iv(int exp, string tag);
    next_rise();
    next_rise();
    check(last_iv == exp, tag, last_iv, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    bit fb0;
    repeat (5) @(negedge clk);
    check(vs_out == 1'b0, "R1 vs_out reset", vs_out, 0);
    check(field_bit == 1'b0, "R1 field_bit reset", field_bit, 0);
    check(range_code == 2'b10, "R1 range_code reset", range_code, 2);
    rst_n = 1'b1;

    // free run, R6
    expect_iv(625, "R6 free 625");
    pulse_at = 100;
    expect_iv(625, "R6 free ignores vp");
    pulse_at = 0;
    term_mode = 1'b1;
    expect_iv(624, "R6 terminal 625");
    std_625 = 1'b0; term_mode = 1'b0;
    expect_iv(525, "R6 free 525");
    repeat (3) next_rise();
    check(range_code == 2'b00, "R9 short in-window", range_code, 0);
    term_mode = 1'b1;
    expect_iv(524, "R6 terminal 525");

    // timeouts, R4
    free_run = 1'b0; term_mode = 1'b0;
    expect_iv(576, "R4 timeout 525");
    repeat (3) next_rise();
    check(range_code == 2'b11, "R9 long out-of-window", range_code, 3);
    std_625 = 1'b1;
    expect_iv(680, "R4 timeout 625");

    // flywheel, R5 and field toggle R8
    fly_en = 1'b1;
    expect_iv(625, "R5 flywheel 625");
    fb0 = last_fb;
    next_rise();
    check(last_fb != fb0, "R8 field toggle", last_fb, !fb0);

    // gate off, R2
    pulse_at = 400;
    expect_iv(400, "R2 gate off pulse");

    // gate on narrow, R3 / R10
    gate_en = 1'b1;
    pulse_at = 600;
    expect_iv(625, "R3 narrow rejects 600");
    pulse_at = 620;
    expect_iv(620, "R3 narrow accepts 620");
    win_wide = 1'b1;
    pulse_at = 600;
    expect_iv(600, "R10 wide accepts 600");
    win_wide = 1'b0;
    std_625 = 1'b0;
    pulse_at = 520;
    expect_iv(520, "R10 narrow 525 accepts 520");

    // field bit forcing, R8
    std_625 = 1'b1;
    pulse_at = 620;
    first_half = 1'b1;
    next_rise();
    next_rise();
    check(field_bit == 1'b0, "R8 forced zero", field_bit, 0);
    next_rise();
    check(field_bit == 1'b0, "R8 forced zero again", field_bit, 0);
    check(last_iv == 620, "R3 gated accept interval", last_iv, 620);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule